// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower block-wide memory. It has a fixed number of lines, a power of two. Each line holds a tag, a valid flag, a modified (dirty) flag and one block of several words. The line is chosen by low-order bits of the block address, so the line number is the block address modulo the line count. A request hits when the selected line is valid and its stored tag equals the upper address bits.

Writes stay in the cache and only set the line's dirty flag. Memory is updated only when a dirty line is evicted. A write miss first brings the whole block in and then merges the word (write-allocate). The work is done by a four-state controller: Idle, Compare, Evict and Refill. Evict runs only when the victim line is dirty. After every refill the controller returns to Compare, so the retried request then completes as an ordinary hit.

The processor holds `cpu_req` and its address and data fields steady until it sees a one-cycle `cpu_ready` pulse. The memory side holds `mem_req` and its fields steady until it sees a one-cycle `mem_ready` pulse.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any address is a miss that reads memory.
- R2: With default parameters, byte address bits [3:2] pick the word in the block, bits [6:4] pick the line and bits [31:7] form the tag. Two addresses that differ only in the tag contend for the same line.
- R3: A read hit raises `cpu_ready` for exactly one cycle, on the second clock edge after `cpu_req` is first sampled, with the stored word on `cpu_rdata`.
- R4: A write hit updates only the addressed word in the cache, makes no memory access and marks the line dirty.
- R5: A miss on an invalid or clean line issues exactly one block read at the block-aligned address and no write. The refill marks the line valid and clean with the new tag, and the request then completes through Compare.
- R6: A miss on a dirty line first writes the old block back, at the address built from the stored tag and the line index with zero offset, and then reads the new block. A later miss on that block returns the written-back data.
- R7: A write miss loads the block from memory and then stores the word. The other words of that block hold their memory values.
- R8: `cpu_ready` is low in every cycle the controller spends waiting on memory. Evict and Refill each hold `mem_req` until `mem_ready` is seen, and a miss never completes in fewer than four cycles.
- R9: `mem_we` is high only during Evict, and only together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory block request |
| mem_we | output | 1 | 1 = block write (eviction), 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Evicted block, word 0 in the low bits |
| mem_rdata | input | 128 | Refill block, word 0 in the low bits, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle memory completion pulse |

## Verification
The hardest case to reach is an eviction of a dirty line whose block is then requested again. Reaching it needs a store, followed by a miss with a different tag on the same line, followed by a return to the first block. The bench confines addresses to a 1 KiB window, which leaves only eight tags per line, so random traffic produces many such conflicts. A directed sequence also walks this case step by step. The memory model varies its response delay on every request, so the Evict and Refill waits are exercised at several lengths. On every eviction it compares the written block against a shadow copy of what the processor has stored.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMP   = 2'd1,
    ST_EVICT = 2'd2,
    ST_FILL  = 2'd3
  } dmc_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             set_dirty,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[idx] <= fill_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];

  // R4
  dirty_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    set_dirty && !fill |=> dirty_q[$past(idx)]);
  // R5
  clean_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fill |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]);
endmodule

// File: rtl/dmc_line_ram.sv
module dmc_line_ram #(
  parameter int LINES = 8,
  parameter int BLK_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [BLK_W-1:0] wdata,
  output logic [BLK_W-1:0] rdata
);
  logic [BLK_W-1:0] mem_q [LINES];

  // write-first synchronous port, maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[idx] <= wdata;
      rdata      <= wdata;
    end else begin
      rdata <= mem_q[idx];
    end
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_req,
  input  logic       ready_busy,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_ready,
  output dmc_state_t state
);
  dmc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (cpu_req && !ready_busy) nxt = ST_CMP;
      ST_CMP:   if (hit) nxt = ST_IDLE;
                else if (victim_dirty) nxt = ST_EVICT;
                else nxt = ST_FILL;
      ST_EVICT: if (mem_ready) nxt = ST_FILL;
      ST_FILL:  if (mem_ready) nxt = ST_CMP;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R6
  evict_wait_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_EVICT && !mem_ready |=> state == ST_EVICT);
  // R6
  evict_to_fill_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_EVICT && mem_ready |=> state == ST_FILL);
  // R5
  fill_to_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_FILL && mem_ready |=> state == ST_CMP);
  // R8
  miss_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_CMP && !hit |=> state != ST_IDLE);
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int BLK_W  = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ready
);
  dmc_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] woff;
  logic [TAG_W-1:0] req_tag;
  logic             line_valid, line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic             hit, store_hit, refill;
  logic [BLK_W-1:0] line_q, merged, ram_wdata;
  logic [DATA_W-1:0] word_sel [WORDS];

  assign idx     = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign woff    = cpu_addr[BYTE_W +: OFF_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  assign hit       = (state == ST_CMP) && line_valid && (line_tag == req_tag);
  assign store_hit = hit && cpu_we;
  assign refill    = (state == ST_FILL) && mem_ready;

  dmc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .ready_busy   (cpu_ready),
    .hit          (hit),
    .victim_dirty (line_valid && line_dirty),
    .mem_ready    (mem_ready),
    .state        (state)
  );

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .idx        (idx),
    .fill       (refill),
    .fill_tag   (req_tag),
    .set_dirty  (store_hit),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_sel[w] = line_q[w*DATA_W +: DATA_W];
    assign merged[w*DATA_W +: DATA_W] =
      (woff == OFF_W'(w)) ? cpu_wdata : line_q[w*DATA_W +: DATA_W];
  end

  assign ram_wdata = refill ? mem_rdata : merged;

  dmc_line_ram #(.LINES(LINES), .BLK_W(BLK_W)) u_data (
    .clk   (clk),
    .we    (refill || store_hit),
    .idx   (idx),
    .wdata (ram_wdata),
    .rdata (line_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= hit;
      if (hit) cpu_rdata <= word_sel[woff];
    end
  end

  assign mem_req   = (state == ST_EVICT) || (state == ST_FILL);
  assign mem_we    = (state == ST_EVICT);
  assign mem_addr  = (state == ST_EVICT)
                   ? {line_tag, idx, {(OFF_W+BYTE_W){1'b0}}}
                   : {req_tag,  idx, {(OFF_W+BYTE_W){1'b0}}};
  assign mem_wdata = line_q;

  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R8
  ready_from_hit_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> $past(state == ST_CMP));
  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we));
  // R9
  we_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

// File: tb/tb_dm_wb_cache.sv
`timescale 1ns/1ps
module tb_dm_wb_cache;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #10 clk = ~clk;

  dm_wb_cache dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int total = 0, bad = 0;
  logic [31:0] backing [256];
  logic [31:0] shadow  [256];
  bit          ref_v [8];
  bit          ref_d [8];
  logic [24:0] ref_tag [8];
  int          n_rd, n_wr, first_wr, wb_bad;
  logic [31:0] wb_addr;

  function automatic logic [31:0] init_word(int i);
    return (i * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with random response delay
  initial begin
    int cnt = 0;
    int lat = 1;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ready = 1'b0; cnt = 0;
      end else if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          if (n_rd == 0 && n_wr == 0) first_wr = mem_we;
          if (mem_we) begin
            n_wr++;
            wb_addr = mem_addr;
            for (int w = 0; w < 4; w++) begin
              if (mem_wdata[w*32 +: 32] !== shadow[mem_addr[9:4]*4 + w]) wb_bad = 1;
              backing[mem_addr[9:4]*4 + w] = mem_wdata[w*32 +: 32];
            end
          end else begin
            n_rd++;
            for (int w = 0; w < 4; w++)
              mem_rdata[w*32 +: 32] = backing[mem_addr[9:4]*4 + w];
          end
          mem_ready = 1'b1;
          cnt = 0;
          lat = $urandom % 4;
        end else cnt++;
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    n_rd = 0; n_wr = 0; first_wr = 0; wb_bad = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 200);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    if (lat >= 200) check(0, "R8", "request never completed", lat, 0);
  endtask

  // predicts the outcome from the reference line state, then checks it
  task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d);
    int          li  = a[6:4];
    logic [24:0] tg  = a[31:7];
    bit          h   = ref_v[li] && ref_tag[li] == tg;
    bit          dv  = !h && ref_v[li] && ref_d[li];
    logic [31:0] old_blk = {ref_tag[li], a[6:4], 4'h0};
    logic [31:0] rd;
    int          lat;
    access(we, a, d, rd, lat);
    if (h) begin
      check(n_rd == 0 && n_wr == 0, we ? "R4" : "R3", "hit memory traffic", n_rd + n_wr, 0);
      check(lat == 2, "R3", "hit latency", lat, 2);
    end else if (dv) begin
      check(n_wr == 1 && n_rd == 1 && first_wr == 1, "R6", "evict order", {n_wr, n_rd}, 1);
      check(wb_addr == old_blk, "R6", "evict address", wb_addr, old_blk);
      check(wb_bad == 0, "R6", "evict data", wb_bad, 0);
      check(lat >= 4, "R8", "miss latency", lat, 4);
    end else begin
      check(n_rd == 1 && n_wr == 0, "R5", "clean miss traffic", {n_rd, n_wr}, 64'h1_0000_0000);
      check(n_wr == 0, "R9", "write outside evict", n_wr, 0);
      check(lat >= 4, "R8", "miss latency", lat, 4);
    end
    if (!we) check(rd == shadow[a[9:2]], h ? "R3" : (we ? "R7" : "R5"), "read data", rd, shadow[a[9:2]]);
    ref_d[li]   = (h && ref_d[li]) || we;
    ref_v[li]   = 1'b1;
    ref_tag[li] = tg;
    if (we) shadow[a[9:2]] = d;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      backing[i] = init_word(i);
      shadow[i]  = init_word(i);
    end
    for (int i = 0; i < 8; i++) begin
      ref_v[i] = 0; ref_d[i] = 0; ref_tag[i] = '0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_ready == 0, "R1", "ready after reset", cpu_ready, 0);
    check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);

    // directed corner cases
    op(0, 32'h040, 0);             // R1 cold miss, R5
    op(0, 32'h044, 0);             // R3 hit in same block
    op(1, 32'h048, 32'hDEADBEEF);  // R4 store hit
    op(0, 32'h048, 0);             // R4 read back
    op(0, 32'h0C0, 0);             // R2 same line, other tag: R6 eviction
    op(0, 32'h048, 0);             // R6 data came back from memory
    op(1, 32'h134, 32'h12345678);  // R7 write miss
    op(0, 32'h130, 0);             // R7 neighbour word from memory
    op(0, 32'h138, 0);
    op(0, 32'h134, 0);
    op(1, 32'h1B4, 32'h0BADF00D);  // R6 evict the block filled by the write miss
    op(0, 32'h134, 0);

    for (int k = 0; k < 400; k++)
      op($urandom % 2, {22'd0, 8'($urandom), 2'b00}, $urandom);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule